// File: doc/BRIEF.md
# Loadable Counter with Snapshot Register and Output Select

The block holds a 4-bit synchronous up counter and a 4-bit storage register. The counter is clocked by its own clock. It can be cleared, preset from four data inputs, or stepped up when both of its count enables are high. A separate register clock copies the current counter value into the storage register. A per-bit two-way selector decides whether the counter or the stored copy drives four three-state outputs. An active-low output enable can float those outputs.

Two parameters pick the variant. `DECADE` makes the counter run 0 to 9 instead of 0 to 15. `ASYNC_CLR` makes the active-low clear act at once instead of at the next counter clock edge. A carry output goes high at terminal count while the second enable is high, so several blocks can be chained into a wider counter.

Top module: `cnt_reg_mux`

## Requirements
- R1: With `clr_n` low the counter becomes 0. This happens at the next rising `cnt_clk` when `ASYNC_CLR`=0, and as soon as `clr_n` falls when `ASYNC_CLR`=1.
- R2: With `clr_n` high and `load_n` low, a rising `cnt_clk` copies `din` into the counter, whatever the enables are.
- R3: With `clr_n` and `load_n` high, the counter holds its value unless `en_p` and `en_t` are both 1.
- R4: The counter steps up by one on each enabled edge. It goes from 15 to 0 when `DECADE`=0, and from 9 to 0 when `DECADE`=1.
- R5: When `DECADE`=1, an enabled count from any value 10 to 15 gives 0 on the next edge.
- R6: `rco` is 1 exactly when `en_t` is 1 and the counter holds its terminal count: 9 when `DECADE`=1, 15 when `DECADE`=0.
- R7: A rising `reg_clk` stores the counter value into the register. When this edge falls together with a counter edge, the register takes the value held before that counter edge.
- R8: With `oe_n` low, `q` shows the counter when `sel_reg`=0 and the register when `sel_reg`=1.
- R9: With `oe_n` high, all four bits of `q` are high impedance.
- R10: Clear overrides load, and load overrides counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_clk | input | 1 | Counter clock, rising edge |
| reg_clk | input | 1 | Register capture clock, rising edge |
| clr_n | input | 1 | Active-low counter clear |
| load_n | input | 1 | Active-low parallel load |
| en_p | input | 1 | Count enable (count only) |
| en_t | input | 1 | Count enable that also gates `rco` |
| sel_reg | input | 1 | Output source: 0 counter, 1 register |
| oe_n | input | 1 | Active-low output enable |
| din | input | 4 | Parallel load data |
| q | output | 4 | Three-state data output |
| rco | output | 1 | Ripple-carry at terminal count |

## Verification
The register capture can fall on the same edge as a counter increment. The bench provokes this by deriving `reg_clk` from `cnt_clk` for one cycle while counting is enabled. It then selects the register and expects the value from before that edge, while the counter itself shows the incremented value.

The bench also raises clear, load and both enables in one cycle. This checks that clear wins, and then that load wins over counting. Binary and decade variants run side by side on the same stimulus, so the wrap points, illegal-state recovery and asynchronous clear are each judged against the other variant.

// File: rtl/cnt_reg_mux.sv
module cnt_reg_mux #(
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic       cnt_clk,
  input  logic       reg_clk,
  input  logic       clr_n,
  input  logic       load_n,
  input  logic       en_p,
  input  logic       en_t,
  input  logic       sel_reg,
  input  logic       oe_n,
  input  logic [3:0] din,
  output logic [3:0] q,
  output logic       rco
);
  localparam logic [3:0] TERM = DECADE ? 4'd9 : 4'd15;

  logic [3:0] cnt, cnt_nxt, rg;
  logic       step;

  assign step    = en_p & en_t;
  assign cnt_nxt = !load_n ? din :
                   step    ? ((cnt >= TERM) ? 4'd0 : cnt + 4'd1) :
                             cnt;

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge cnt_clk or negedge clr_n)
        if (!clr_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end else begin : g_sclr
      always_ff @(posedge cnt_clk)
        cnt <= clr_n ? cnt_nxt : 4'd0;
    end
  endgenerate

  always_ff @(posedge reg_clk)
    rg <= cnt;

  assign rco = en_t & (cnt == TERM);
  assign q   = oe_n ? 4'bzzzz : (sel_reg ? rg : cnt);

  a_r1_clear_zero: assert property (@(posedge cnt_clk)
    !clr_n |=> cnt == 4'd0);

  a_r2_load_data: assert property (@(posedge cnt_clk) disable iff (!clr_n)
    !load_n |=> cnt == $past(din));

  a_r3_hold_idle: assert property (@(posedge cnt_clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(cnt));

  a_r4_wrap_term: assert property (@(posedge cnt_clk) disable iff (!clr_n)
    (load_n && en_p && en_t && cnt == TERM) |=> cnt == 4'd0);

  a_r5_illegal_exit: assert property (@(posedge cnt_clk) disable iff (!clr_n)
    (DECADE && load_n && en_p && en_t && cnt > 4'd9) |=> cnt == 4'd0);

  a_r7_snapshot: assert property (@(posedge reg_clk) disable iff (!clr_n)
    1'b1 |=> rg == $past(cnt));
endmodule

// File: tb/cnt_reg_mux_tb_top.sv
module cnt_reg_mux_tb_top;
  localparam int CLK_PERIOD = 10;

  logic cnt_clk = 1'b0;
  logic reg_man = 1'b0, tie = 1'b0;
  logic clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic sel_reg = 1'b0, oe_n = 1'b0;
  logic [3:0] din = '0;
  wire  reg_clk = tie ? cnt_clk : reg_man;
  tri1 [3:0] q_b, q_d;
  wire rco_b, rco_d;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) cnt_clk = ~cnt_clk;

  cnt_reg_mux #(.DECADE(1'b0), .ASYNC_CLR(1'b0)) dut_i (
    .cnt_clk(cnt_clk), .reg_clk(reg_clk), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .sel_reg(sel_reg), .oe_n(oe_n), .din(din),
    .q(q_b), .rco(rco_b));

  cnt_reg_mux #(.DECADE(1'b1), .ASYNC_CLR(1'b1)) dut_dec_i (
    .cnt_clk(cnt_clk), .reg_clk(reg_clk), .clr_n(clr_n), .load_n(load_n),
    .en_p(en_p), .en_t(en_t), .sel_reg(sel_reg), .oe_n(oe_n), .din(din),
    .q(q_d), .rco(rco_d));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge cnt_clk); #1;
  endtask

  task automatic t_reset();
    clr_n = 1'b0; tick(); clr_n = 1'b1;
    chk("R1 sync clear bin", q_b, 4'd0);
    chk("R1 clear dec", q_d, 4'd0);
  endtask

  task automatic t_load();
    din = 4'd6; load_n = 1'b0; tick(); load_n = 1'b1;
    chk("R2 load bin", q_b, 4'd6);
    chk("R2 load dec", q_d, 4'd6);
    tick();
    chk("R3 hold no enable", q_b, 4'd6);
  endtask

  task automatic t_count();
    en_p = 1'b1; en_t = 1'b1;
    repeat (3) tick();
    chk("R4 count bin", q_b, 4'd9);
    chk("R4 count dec", q_d, 4'd9);
    chk("R6 rco dec at 9", {3'b0, rco_d}, 4'd1);
    chk("R6 rco bin at 9", {3'b0, rco_b}, 4'd0);
    tick();
    chk("R4 bin past 9", q_b, 4'd10);
    chk("R4 dec wrap 9", q_d, 4'd0);
    en_p = 1'b0; tick();
    chk("R3 hold en_p low", q_b, 4'd10);
    en_t = 1'b0;
  endtask

  task automatic t_bin_wrap();
    din = 4'd14; load_n = 1'b0; tick(); load_n = 1'b1;
    en_p = 1'b1; en_t = 1'b1; tick();
    chk("R6 rco bin at 15", {3'b0, rco_b}, 4'd1);
    chk("R5 dec from 14", q_d, 4'd0);
    tick();
    chk("R4 bin wrap 15", q_b, 4'd0);
    en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_illegal();
    din = 4'd12; load_n = 1'b0; tick(); load_n = 1'b1;
    en_t = 1'b1;
    chk("R6 rco dec illegal", {3'b0, rco_d}, 4'd0);
    en_p = 1'b1; tick();
    chk("R5 dec from 12", q_d, 4'd0);
    chk("R4 bin from 12", q_b, 4'd13);
    en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_priority();
    din = 4'd5; clr_n = 1'b0; load_n = 1'b0; en_p = 1'b1; en_t = 1'b1;
    tick();
    chk("R10 clear over load", q_b, 4'd0);
    clr_n = 1'b1; tick();
    chk("R10 load over count", q_b, 4'd5);
    chk("R10 load over count dec", q_d, 4'd5);
    load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_register();
    #1 reg_man = 1'b1; #1 reg_man = 1'b0;
    sel_reg = 1'b1; #1;
    chk("R8 select register", q_b, 4'd5);
    en_p = 1'b1; en_t = 1'b1; tick();
    chk("R7 register kept", q_b, 4'd5);
    sel_reg = 1'b0; #1;
    chk("R8 select counter", q_b, 4'd6);
    @(negedge cnt_clk); tie = 1'b1;
    tick(); tie = 1'b0;
    chk("R7 counter on shared edge", q_b, 4'd7);
    sel_reg = 1'b1; #1;
    chk("R7 register pre-edge value", q_b, 4'd6);
    sel_reg = 1'b0; en_p = 1'b0; en_t = 1'b0;
  endtask

  task automatic t_async();
    clr_n = 1'b0; #1;
    chk("R1 async clear immediate", q_d, 4'd0);
    chk("R1 sync clear waits", q_b, 4'd7);
    tick();
    chk("R1 sync clear at edge", q_b, 4'd0);
    clr_n = 1'b1;
  endtask

  task automatic t_oe();
    din = 4'd4; load_n = 1'b0; tick(); load_n = 1'b1;
    oe_n = 1'b1; #1;
    chk("R9 float bin", q_b, 4'b1111);
    chk("R9 float dec", q_d, 4'b1111);
    oe_n = 1'b0; #1;
    chk("R9 drive again", q_b, 4'd4);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_load();
    t_count();
    t_bin_wrap();
    t_illegal();
    t_priority();
    t_register();
    t_async();
    t_oe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule